// File: doc/BRIEF.md
# NVM External Programming Access Controller

This block sits between an external debug/programming port and the on-chip non-volatile memory. The host first opens access with a fixed handshake: it writes a reset signature and then a 64-bit key, one byte at a time. Only when every key byte matches does the block raise its enable flag, which the host reads back by polling a status register. While the flag is set, the whole memory appears in one byte-addressed space. The host reaches it through a simple single-cycle read/write bus.

Once access is open, a command register selects what happens next, and each command is started in one of three ways. Array reads start on a load from the memory space. Page-buffer fills, page erase and page write start on a store to the memory space. Chip erase and CRC start when the host sets an execute bit in a control register. Erase, write, chip erase and CRC run on the memory array through a start/done handshake. While one of them is in flight the block is busy, and all memory reads are refused.

Two lock inputs restrict the command set. When both locks are active, only chip erase and CRC are accepted. Any other command is refused: it raises an error flag and changes nothing. The page buffer holds 64 bytes. It is indexed by the six low address bits, and a page operation takes its page number from the remaining upper address bits.

Top module: `nvmx_access_ctrl`

## Requirements
- R1: After reset, nvm_on, busy, bus_rvalid, bus_blocked and mem_start are 0, and every page-buffer byte reads 0x00 on mem_buf_data.
- R2: Writing 0x59 to register 0 (control space) and then the eight bytes of the 64-bit key to register 1, least significant byte first, sets nvm_on after the last key write. The default key is 0xC3A51F609E27D84B. The flag also reads as bit 0 of the status register (register 2).
- R3: A key byte that does not match clears the sequence and leaves nvm_on at 0, and later key writes are ignored until a new 0x59 arrives. Any write to register 0 clears nvm_on.
- R4: Every bus read gives bus_rvalid and bus_rdata one cycle after the read strobe. The status register has bit 0 for enabled, bit 1 for busy and bit 2 for error. Register 3 reads back the 3-bit command code.
- R5: With command 1 (read) in force, a load from the memory space drives mem_rd in the same cycle, with mem_addr equal to the bus address. The following cycle returns mem_rdata on bus_rdata.
- R6: With command 2 (buffer load) in force, a store writes the data byte into the page-buffer entry given by address bits [5:0], whatever the upper address bits hold. The entry can be read on mem_buf_data at mem_buf_idx.
- R7: With command 3 (page erase) or 4 (page write) in force, a store pulses mem_start for exactly one cycle, starting the cycle after the store. At the same time mem_op equals the command and mem_page equals address bits [23:6]. busy stays 1 until mem_done is seen.
- R8: Writing register 4 with bit 0 set, while command 5 (chip erase) or 6 (CRC) is in force, starts that operation with mem_page 0. A register 4 write with bit 0 clear, or with any other command in force, starts nothing.
- R9: While busy, a load from the memory space returns 0x00 with bus_blocked set and no mem_rd. Stores and execute-bit writes made while busy are ignored.
- R10: With both lock_rd and lock_wr set, only commands 5 and 6 run. Any other command, when triggered, sets the error bit and changes nothing: no mem_rd, no buffer write, no start, and a load returns 0x00. Writing the status register with bit 2 set clears the error bit.
- R11: When a page write completes (mem_done while busy), every page-buffer entry becomes 0x00. A completed page erase leaves the buffer unchanged.
- R12: While nvm_on is 0, memory-space loads return 0x00 without mem_rd, memory-space stores leave the buffer unchanged, and execute-bit writes start nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ctl | input | 1 | 1 selects the control register space, 0 the memory space |
| bus_addr | input | 24 | Byte address |
| bus_wr | input | 1 | Store strobe |
| bus_rd | input | 1 | Load strobe |
| bus_wdata | input | 8 | Store data |
| bus_rdata | output | 8 | Load data, one cycle after the strobe |
| bus_rvalid | output | 1 | Load data valid |
| bus_blocked | output | 1 | Load refused because the array is busy |
| lock_rd | input | 1 | Read lock |
| lock_wr | input | 1 | Write lock |
| nvm_on | output | 1 | External access enabled |
| busy | output | 1 | Array operation in flight |
| mem_rd | output | 1 | Array read strobe |
| mem_addr | output | 24 | Array read address |
| mem_rdata | input | 8 | Array read data for mem_addr |
| mem_start | output | 1 | Start pulse for erase/write/CRC |
| mem_op | output | 3 | Operation code, equal to the command code |
| mem_page | output | 18 | Page number of the operation |
| mem_done | input | 1 | Operation complete |
| mem_buf_idx | input | 6 | Page-buffer read index for the array |
| mem_buf_data | output | 8 | Page-buffer byte at mem_buf_idx |

## Verification
The hardest situation to reach is a host access that arrives in the middle of an array operation. To create it, the bench starts a page erase and then holds mem_done back for a random number of cycles. During that window it issues loads and stores and checks that nothing gets through. A second hard case is the mixed lock state: the bench makes a refused command and an accepted one follow each other under the same lock setting. A third is a key sequence that fails part-way and is then continued with the correct remaining bytes. Random buffer fills with random upper address bits, and random array reads, cover the data paths around these directed cases.

// File: rtl/nvmx_pkg.sv
package nvmx_pkg;

    localparam logic [7:0] RESET_SIG = 8'h59;

    localparam logic [2:0] REG_SIG  = 3'd0;
    localparam logic [2:0] REG_KEY  = 3'd1;
    localparam logic [2:0] REG_STAT = 3'd2;
    localparam logic [2:0] REG_CMD  = 3'd3;
    localparam logic [2:0] REG_CTRL = 3'd4;

    localparam logic [2:0] CMD_NOP       = 3'd0;
    localparam logic [2:0] CMD_READ      = 3'd1;
    localparam logic [2:0] CMD_BUFLD     = 3'd2;
    localparam logic [2:0] CMD_PERASE    = 3'd3;
    localparam logic [2:0] CMD_PWRITE    = 3'd4;
    localparam logic [2:0] CMD_CHIPERASE = 3'd5;
    localparam logic [2:0] CMD_CRC       = 3'd6;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_KEY = 2'd1,
        ST_ON  = 2'd2
    } unlock_e;

    function automatic logic cmd_is_action(logic [2:0] c);
        return (c == CMD_CHIPERASE) || (c == CMD_CRC);
    endfunction

    function automatic logic cmd_is_store(logic [2:0] c);
        return (c == CMD_BUFLD) || (c == CMD_PERASE) || (c == CMD_PWRITE);
    endfunction

    function automatic logic cmd_lock_exempt(logic [2:0] c);
        return (c == CMD_CHIPERASE) || (c == CMD_CRC);
    endfunction

endpackage

// File: rtl/nvmx_unlock.sv
module nvmx_unlock
    import nvmx_pkg::*;
#(
    parameter int KEY_BYTES = 8,
    parameter logic [8*KEY_BYTES-1:0] KEY_VAL = 64'hC3A5_1F60_9E27_D84B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_we,
    input  logic       key_we,
    input  logic [7:0] wdata,
    output logic       on
);
    localparam int IW = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;

    typedef struct packed {
        unlock_e         stage;
        logic [IW-1:0]   idx;
    } ul_t;

    ul_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sig_we) begin
            st_d.idx = '0;
            st_d.stage = (wdata == RESET_SIG) ? ST_KEY : ST_OFF;
        end else if (key_we && st_q.stage == ST_KEY) begin
            if (wdata == KEY_VAL[st_q.idx*8 +: 8]) begin
                if (st_q.idx == IW'(KEY_BYTES - 1)) begin
                    st_d.stage = ST_ON;
                    st_d.idx   = '0;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end else begin
                st_d.stage = ST_OFF;
                st_d.idx   = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{stage: ST_OFF, idx: '0};
        else        st_q <= st_d;
    end

    assign on = (st_q.stage == ST_ON);

    AST_ON_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on) |-> $past(key_we)) else $error("enable without key write"); // R2
    AST_SIG_DROPS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        sig_we |=> !on) else $error("enable survived signature write"); // R3

endmodule

// File: rtl/nvmx_pagebuf.sv
module nvmx_pagebuf #(
    parameter int DEPTH = 64,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] widx,
    input  logic [7:0]      wdata,
    input  logic            clr,
    input  logic [IDXW-1:0] ridx,
    output logic [7:0]      rdata
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] cells;
    } pb_t;

    pb_t pb_d, pb_q;

    always_comb begin
        pb_d = pb_q;
        if (clr) begin
            pb_d.cells = '0;
        end else if (we) begin
            pb_d.cells[widx] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pb_q <= '0;
        else        pb_q <= pb_d;
    end

    assign rdata = pb_q.cells[ridx];

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pb_q.cells == '0)) else $error("buffer not empty after clear"); // R11

endmodule

// File: rtl/nvmx_cmd.sv
module nvmx_cmd
    import nvmx_pkg::*;
#(
    parameter int AW  = 24,
    parameter int PBW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            on,
    input  logic            cmd_we,
    input  logic [2:0]      cmd_wdata,
    input  logic            trig_act,
    input  logic            ld,
    input  logic            st,
    input  logic [AW-PBW-1:0] page_in,
    input  logic            lock_rd,
    input  logic            lock_wr,
    input  logic            mem_done,
    input  logic            err_clr,
    output logic [2:0]      cmd,
    output logic            busy,
    output logic            err,
    output logic            rd_go,
    output logic            blocked,
    output logic            buf_we,
    output logic            buf_clr,
    output logic            mem_start,
    output logic [2:0]      mem_op,
    output logic [AW-PBW-1:0] mem_page
);
    localparam int PGW = AW - PBW;

    typedef struct packed {
        logic [2:0]     cmd;
        logic           busy;
        logic           err;
        logic           start;
        logic [2:0]     op;
        logic [PGW-1:0] page;
    } cs_t;

    cs_t cs_d, cs_q;
    logic locked;
    logic hit;

    always_comb begin
        cs_d    = cs_q;
        cs_d.start = 1'b0;
        rd_go   = 1'b0;
        buf_we  = 1'b0;
        buf_clr = 1'b0;
        locked  = lock_rd & lock_wr;
        hit     = 1'b0;

        if (cmd_we)  cs_d.cmd = cmd_wdata;
        if (err_clr) cs_d.err = 1'b0;

        if (cs_q.busy && mem_done) begin
            cs_d.busy = 1'b0;
            buf_clr   = (cs_q.op == CMD_PWRITE);
        end

        if (on && !cs_q.busy) begin
            hit = (trig_act && cmd_is_action(cs_q.cmd))
               || (ld && cs_q.cmd == CMD_READ)
               || (st && cmd_is_store(cs_q.cmd));
            if (hit) begin
                if (locked && !cmd_lock_exempt(cs_q.cmd)) begin
                    cs_d.err = 1'b1;
                end else if (cs_q.cmd == CMD_READ) begin
                    rd_go = 1'b1;
                end else if (cs_q.cmd == CMD_BUFLD) begin
                    buf_we = 1'b1;
                end else begin
                    cs_d.busy  = 1'b1;
                    cs_d.start = 1'b1;
                    cs_d.op    = cs_q.cmd;
                    cs_d.page  = cmd_is_action(cs_q.cmd) ? '0 : page_in;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign cmd       = cs_q.cmd;
    assign busy      = cs_q.busy;
    assign err       = cs_q.err;
    assign mem_start = cs_q.start;
    assign mem_op    = cs_q.op;
    assign mem_page  = cs_q.page;
    assign blocked   = ld && on && cs_q.busy;

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |=> !mem_start) else $error("start longer than one cycle"); // R7
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mem_done |=> busy) else $error("busy dropped without done"); // R7
    AST_LOCK_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start && $past(lock_rd && lock_wr) |-> (mem_op == CMD_CHIPERASE || mem_op == CMD_CRC))
        else $error("locked command started"); // R10

endmodule

// File: rtl/nvmx_access_ctrl.sv
module nvmx_access_ctrl
    import nvmx_pkg::*;
#(
    parameter int AW        = 24,
    parameter int BUF_BYTES = 64,
    parameter int KEY_BYTES = 8,
    parameter logic [8*KEY_BYTES-1:0] KEY_VAL = 64'hC3A5_1F60_9E27_D84B,
    localparam int PBW = $clog2(BUF_BYTES),
    localparam int PGW = AW - PBW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_ctl,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [7:0]     bus_wdata,
    output logic [7:0]     bus_rdata,
    output logic           bus_rvalid,
    output logic           bus_blocked,
    input  logic           lock_rd,
    input  logic           lock_wr,
    output logic           nvm_on,
    output logic           busy,
    output logic           mem_rd,
    output logic [AW-1:0]  mem_addr,
    input  logic [7:0]     mem_rdata,
    output logic           mem_start,
    output logic [2:0]     mem_op,
    output logic [PGW-1:0] mem_page,
    input  logic           mem_done,
    input  logic [PBW-1:0] mem_buf_idx,
    output logic [7:0]     mem_buf_data
);
    typedef struct packed {
        logic [7:0] rdata;
        logic       rvalid;
        logic       blocked;
    } rp_t;

    rp_t rp_d, rp_q;

    logic [2:0] reg_sel;
    logic ctl_wr, ctl_rd, nvm_st, nvm_ld;
    logic sig_we, key_we, cmd_we, err_clr, trig_act;
    logic [2:0] cmd;
    logic err, rd_go, blocked, buf_we, buf_clr;

    assign reg_sel  = bus_addr[2:0];
    assign ctl_wr   = bus_wr &  bus_ctl;
    assign ctl_rd   = bus_rd &  bus_ctl;
    assign nvm_st   = bus_wr & ~bus_ctl;
    assign nvm_ld   = bus_rd & ~bus_ctl;
    assign sig_we   = ctl_wr && reg_sel == REG_SIG;
    assign key_we   = ctl_wr && reg_sel == REG_KEY;
    assign cmd_we   = ctl_wr && reg_sel == REG_CMD;
    assign err_clr  = ctl_wr && reg_sel == REG_STAT && bus_wdata[2];
    assign trig_act = ctl_wr && reg_sel == REG_CTRL && bus_wdata[0];

    nvmx_unlock #(.KEY_BYTES(KEY_BYTES), .KEY_VAL(KEY_VAL)) i_unlock (
        .clk(clk), .rst_n(rst_n), .sig_we(sig_we), .key_we(key_we),
        .wdata(bus_wdata), .on(nvm_on)
    );

    nvmx_cmd #(.AW(AW), .PBW(PBW)) i_cmd (
        .clk(clk), .rst_n(rst_n), .on(nvm_on), .cmd_we(cmd_we),
        .cmd_wdata(bus_wdata[2:0]), .trig_act(trig_act), .ld(nvm_ld), .st(nvm_st),
        .page_in(bus_addr[AW-1:PBW]), .lock_rd(lock_rd), .lock_wr(lock_wr),
        .mem_done(mem_done), .err_clr(err_clr), .cmd(cmd), .busy(busy), .err(err),
        .rd_go(rd_go), .blocked(blocked), .buf_we(buf_we), .buf_clr(buf_clr),
        .mem_start(mem_start), .mem_op(mem_op), .mem_page(mem_page)
    );

    nvmx_pagebuf #(.DEPTH(BUF_BYTES)) i_pagebuf (
        .clk(clk), .rst_n(rst_n), .we(buf_we), .widx(bus_addr[PBW-1:0]),
        .wdata(bus_wdata), .clr(buf_clr), .ridx(mem_buf_idx), .rdata(mem_buf_data)
    );

    assign mem_rd   = rd_go;
    assign mem_addr = bus_addr;

    always_comb begin
        rp_d.rvalid  = bus_rd;
        rp_d.rdata   = 8'h00;
        rp_d.blocked = 1'b0;
        if (ctl_rd) begin
            case (reg_sel)
                REG_STAT: rp_d.rdata = {5'b0, err, busy, nvm_on};
                REG_CMD:  rp_d.rdata = {5'b0, cmd};
                default:  rp_d.rdata = 8'h00;
            endcase
        end else if (nvm_ld) begin
            rp_d.blocked = blocked;
            if (rd_go) rp_d.rdata = mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rp_q <= '0;
        else        rp_q <= rp_d;
    end

    assign bus_rdata   = rp_q.rdata;
    assign bus_rvalid  = rp_q.rvalid;
    assign bus_blocked = rp_q.blocked;

    AST_BLOCKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_blocked |-> (bus_rdata == 8'h00 && bus_rvalid)) else $error("blocked read leaked data"); // R9
    AST_RD_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (nvm_on && !busy)) else $error("array read while closed or busy"); // R12
    AST_START_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |-> $past(nvm_on)) else $error("start while closed"); // R12

endmodule

// File: tb/test_nvmx_access_ctrl.sv
module test_nvmx_access_ctrl;

    localparam logic [63:0] KEY = 64'hC3A5_1F60_9E27_D84B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_ctl = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid, bus_blocked;
    logic        lock_rd = 1'b0, lock_wr = 1'b0;
    logic        nvm_on, busy, mem_rd, mem_start, mem_done = 1'b0;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [2:0]  mem_op;
    logic [17:0] mem_page;
    logic [5:0]  mem_buf_idx = '0;
    logic [7:0]  mem_buf_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] bufm [64];

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_fn(logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    assign mem_rdata = mem_fn(mem_addr);

    nvmx_access_ctrl i_nvmx_access_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_ctl(bus_ctl), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_blocked(bus_blocked),
        .lock_rd(lock_rd), .lock_wr(lock_wr), .nvm_on(nvm_on), .busy(busy),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_start(mem_start), .mem_op(mem_op), .mem_page(mem_page),
        .mem_done(mem_done), .mem_buf_idx(mem_buf_idx), .mem_buf_data(mem_buf_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic ctl, input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_ctl = ctl; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic ctl, input logic [23:0] a, output logic [7:0] d,
                      output logic blk, output logic mrd, output logic [23:0] maddr,
                      output logic vld);
        @(negedge clk);
        bus_ctl = ctl; bus_addr = a; bus_rd = 1'b1;
        #1;
        mrd = mem_rd; maddr = mem_addr;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; blk = bus_blocked; vld = bus_rvalid;
    endtask

    task automatic rd_stat(output logic [7:0] s);
        logic b, m, v; logic [23:0] ma;
        rd(1'b1, 24'd2, s, b, m, ma, v);
    endtask

    task automatic finish_op();
        @(negedge clk); mem_done = 1'b1;
        @(negedge clk); mem_done = 1'b0;
    endtask

    task automatic unlock_seq();
        wr(1'b1, 24'd0, 8'h59);
        for (int i = 0; i < 8; i++) wr(1'b1, 24'd1, KEY[i*8 +: 8]);
    endtask

    task automatic cmp_buf(input string req);
        for (int i = 0; i < 64; i++) begin
            mem_buf_idx = 6'(i);
            #1;
            chk(req, {24'd0, mem_buf_data}, {24'd0, bufm[i]});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d, s; logic b, m, v; logic [23:0] ma, a;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 64; i++) bufm[i] = 8'h00;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 on", {31'd0, nvm_on}, 0);
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 rvalid", {31'd0, bus_rvalid}, 0);
        chk("R1 blocked", {31'd0, bus_blocked}, 0);
        chk("R1 start", {31'd0, mem_start}, 0);
        rst_n = 1'b1;
        cmp_buf("R1 buffer empty");

        // R4 status read, one-cycle latency
        rd_stat(s);
        chk("R4 status closed", {24'd0, s}, 0);

        // R12 closed: store, load, execute bit
        wr(1'b1, 24'd3, 8'd2);
        wr(1'b0, 24'h000005, 8'hAA);
        cmp_buf("R12 store ignored while closed");
        wr(1'b1, 24'd3, 8'd1);
        rd(1'b0, 24'h001234, d, b, m, ma, v);
        chk("R12 load closed data", {24'd0, d}, 0);
        chk("R12 load closed no mem_rd", {31'd0, m}, 0);
        wr(1'b1, 24'd3, 8'd5);
        wr(1'b1, 24'd4, 8'h01);
        chk("R12 execute closed no start", {31'd0, mem_start}, 0);

        // R3 wrong key byte, then remaining correct bytes ignored
        wr(1'b1, 24'd0, 8'h59);
        for (int i = 0; i < 3; i++) wr(1'b1, 24'd1, KEY[i*8 +: 8]);
        wr(1'b1, 24'd1, KEY[31:24] ^ 8'h01);
        chk("R3 wrong byte", {31'd0, nvm_on}, 0);
        for (int i = 4; i < 8; i++) wr(1'b1, 24'd1, KEY[i*8 +: 8]);
        chk("R3 later bytes ignored", {31'd0, nvm_on}, 0);

        // R2 correct sequence
        unlock_seq();
        chk("R2 nvm_on", {31'd0, nvm_on}, 1);
        rd_stat(s);
        chk("R2 status bit0", {24'd0, s}, 8'h01);

        // R4 command readback
        wr(1'b1, 24'd3, 8'd1);
        rd(1'b1, 24'd3, d, b, m, ma, v);
        chk("R4 cmd readback", {24'd0, d}, 1);
        chk("R4 rvalid", {31'd0, v}, 1);

        // R5 random array reads
        for (int i = 0; i < 20; i++) begin
            a = 24'($urandom);
            rd(1'b0, a, d, b, m, ma, v);
            chk("R5 mem_rd", {31'd0, m}, 1);
            chk("R5 mem_addr", {8'd0, ma}, {8'd0, a});
            chk("R5 data", {24'd0, d}, {24'd0, mem_fn(a)});
        end

        // R6 random buffer fills with random upper bits
        wr(1'b1, 24'd3, 8'd2);
        for (int i = 0; i < 40; i++) begin
            a = 24'($urandom);
            d = 8'($urandom);
            wr(1'b0, a, d);
            bufm[a[5:0]] = d;
        end
        cmp_buf("R6 buffer contents");

        // R7/R9 page erase and accesses while busy
        wr(1'b1, 24'd3, 8'd3);
        wr(1'b0, 24'hABCDE7, 8'h00);
        chk("R7 start pulse", {31'd0, mem_start}, 1);
        chk("R7 op erase", {29'd0, mem_op}, 3);
        chk("R7 page", {14'd0, mem_page}, {14'd0, 18'(24'hABCDE7 >> 6)});
        @(negedge clk);
        chk("R7 start one cycle", {31'd0, mem_start}, 0);
        rd_stat(s);
        chk("R7 status busy", {24'd0, s}, 8'h03);
        rd(1'b0, 24'h000010, d, b, m, ma, v);
        chk("R9 blocked data", {24'd0, d}, 0);
        chk("R9 blocked flag", {31'd0, b}, 1);
        chk("R9 no mem_rd", {31'd0, m}, 0);
        wr(1'b0, 24'h000040, 8'h00);
        chk("R9 store ignored", {31'd0, mem_start}, 0);
        repeat ($urandom_range(1, 6)) begin
            @(negedge clk);
            chk("R7 busy held", {31'd0, busy}, 1);
        end
        finish_op();
        chk("R7 busy cleared", {31'd0, busy}, 0);
        cmp_buf("R11 erase keeps buffer");

        // R7/R11 page write, buffer seen by array then cleared
        wr(1'b1, 24'd3, 8'd4);
        wr(1'b0, 24'h012345, 8'h00);
        chk("R7 op write", {29'd0, mem_op}, 4);
        cmp_buf("R6 buffer at write start");
        repeat ($urandom_range(1, 6)) @(negedge clk);
        finish_op();
        for (int i = 0; i < 64; i++) bufm[i] = 8'h00;
        cmp_buf("R11 cleared after write");

        // R8 action trigger
        wr(1'b1, 24'd3, 8'd5);
        wr(1'b1, 24'd4, 8'h00);
        chk("R8 bit0 clear no start", {31'd0, mem_start}, 0);
        wr(1'b1, 24'd4, 8'h01);
        chk("R8 chip erase start", {31'd0, mem_start}, 1);
        chk("R8 op chip erase", {29'd0, mem_op}, 5);
        chk("R8 page zero", {14'd0, mem_page}, 0);
        wr(1'b1, 24'd4, 8'h01);
        chk("R9 execute ignored while busy", {31'd0, mem_start}, 0);
        finish_op();
        wr(1'b1, 24'd3, 8'd2);
        wr(1'b1, 24'd4, 8'h01);
        chk("R8 non-action no start", {31'd0, mem_start}, 0);
        chk("R8 non-action not busy", {31'd0, busy}, 0);

        // R10 locks
        lock_rd = 1'b1; lock_wr = 1'b1;
        wr(1'b1, 24'd3, 8'd1);
        rd(1'b0, 24'h00BEEF, d, b, m, ma, v);
        chk("R10 locked read data", {24'd0, d}, 0);
        chk("R10 locked read no mem_rd", {31'd0, m}, 0);
        rd_stat(s);
        chk("R10 err set", {24'd0, s}, 8'h05);
        wr(1'b1, 24'd2, 8'h04);
        rd_stat(s);
        chk("R10 err cleared", {24'd0, s}, 8'h01);
        wr(1'b1, 24'd3, 8'd2);
        wr(1'b0, 24'h000007, 8'h77);
        cmp_buf("R10 locked store no change");
        rd_stat(s);
        chk("R10 err after store", {24'd0, s}, 8'h05);
        wr(1'b1, 24'd2, 8'h04);
        wr(1'b1, 24'd3, 8'd4);
        wr(1'b0, 24'h000100, 8'h00);
        chk("R10 locked write no start", {31'd0, mem_start}, 0);
        wr(1'b1, 24'd3, 8'd6);
        wr(1'b1, 24'd4, 8'h01);
        chk("R10 crc runs", {31'd0, mem_start}, 1);
        chk("R10 op crc", {29'd0, mem_op}, 6);
        finish_op();
        lock_rd = 1'b0;
        wr(1'b1, 24'd2, 8'h04);
        wr(1'b1, 24'd3, 8'd1);
        rd(1'b0, 24'h00BEEF, d, b, m, ma, v);
        chk("R10 single lock read ok", {24'd0, d}, {24'd0, mem_fn(24'h00BEEF)});
        lock_wr = 1'b0;

        // R3 signature write drops enable
        wr(1'b1, 24'd0, 8'h00);
        chk("R3 drop enable", {31'd0, nvm_on}, 0);
        unlock_seq();
        chk("R2 re-open", {31'd0, nvm_on}, 1);
        wr(1'b1, 24'd0, 8'h59);
        chk("R3 signature restarts", {31'd0, nvm_on}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule